// File: doc/BRIEF.md
# Transmit Burst Ramp Phase Sequencer

This block produces the digital switch-control phases that shape one transmit burst. A free-running divider turns the master clock into a cycle tick, one master clock in every `TICK_DIV` (six by default). All burst timing is counted in these ticks. The trigger input is synchronised to the master clock and sampled on each tick. It then passes through a short delay line before its edges reach the phase state machine.

The state machine has four named states. `PH_HOME` (code 0) holds the controller at its rest point. `PH_KICK` (code 1) applies the start-up kick. `PH_LEVEL` (code 2) applies the programmed power level. `PH_QDOWN` (code 3) drives the fast ramp-down. There are five transitions:

- A delayed rising trigger edge moves HOME to KICK.
- After a fixed count of kick ticks, KICK moves to LEVEL.
- A delayed falling trigger edge moves LEVEL to QDOWN.
- A delayed falling edge also moves KICK to QDOWN; this is the abort.
- After a fixed count of ramp-down ticks, QDOWN moves to HOME.

Power-down (`run` low) and reset force HOME. Every state element is a flop on the master clock, so a stopped clock freezes the sequence, and it resumes where it stood.

Top module: `burst_ramp_sequencer`

## Requirements
- R1: While `rst_n` is low, `home_en` is 1, `kick_en`, `level_en` and `qdown_en` are 0, and `phase` is 0.
- R2: A tick occurs on every sixth master clock edge after reset release (edges 6, 12, 18, ...). The state changes only on tick edges, or on an edge where `run` is low.
- R3: `trig_in` passes through two master-clock flops and is then sampled on each tick. Let tick n be the first tick whose sample is high after a low one. In HOME, the state becomes KICK (`phase` 1) at tick n+2.
- R4: KICK lasts exactly 18 ticks and then becomes LEVEL (`phase` 2), unless a falling edge arrives first.
- R5: LEVEL is held for as long as no delayed falling edge arrives.
- R6: Let tick m be the first tick whose sample is low after a high one. In LEVEL, the state becomes QDOWN (`phase` 3) at tick m+2.
- R7: A delayed falling edge that arrives during KICK moves the state directly to QDOWN. This includes an edge that arrives on the same tick on which KICK would end, so that LEVEL is never entered.
- R8: QDOWN lasts exactly 38 ticks and then becomes HOME.
- R9: Trigger edges are acted on only at their delayed arrival. A rising edge arriving in QDOWN is ignored, and so is a falling edge arriving in HOME. A trigger still held high when HOME is re-entered does not start a new burst.
- R10: If `run` is low at a master clock edge, the state is HOME after that edge. Edges that arrive while `run` is low are discarded.
- R11: Exactly one of the four enables is high at any time, and `phase` carries the code of the active phase.
- R12: When the master clock stops, all outputs hold. Once the clock restarts, the remaining phase durations continue, counted in ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_mc | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | 1 = operating, 0 = power-down; synchronous to `clk_mc` |
| trig_in | input | 1 | Burst trigger; asynchronous |
| home_en | output | 1 | Home phase enable |
| kick_en | output | 1 | Kick phase enable |
| level_en | output | 1 | Power-level phase enable |
| qdown_en | output | 1 | Quick ramp-down enable |
| phase | output | 2 | Phase code: 0 home, 1 kick, 2 level, 3 quick-down |

## Verification
The assertions are checked on every cycle. They check the following:

- The divider never produces two ticks in a row.
- The state moves only on a tick or under power-down.
- Each state is entered only from its legal predecessor.
- Power-down always leaves the machine in HOME.

Only the bench scenarios can show the exact tick counts. These are the 2-tick trigger delay, the 18-tick kick and the 38-tick ramp-down. The bench compares every cycle against a timeline computed from the times at which it drove the trigger. The scenarios also cover the abort that lands on the last kick tick, ignored and discarded edges, and a paused master clock.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        PH_HOME  = 2'd0,
        PH_KICK  = 2'd1,
        PH_LEVEL = 2'd2,
        PH_QDOWN = 2'd3
    } phase_e;

endpackage

// File: rtl/cycle_tick_gen.sv
module cycle_tick_gen #(
    parameter int TICK_DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (div_q == LAST)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);

    // R2: a tick is never followed directly by another tick
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/trig_edge_sense.sv
module trig_edge_sense #(
    parameter int SYNC_STAGES = 2,
    parameter int DELAY_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic trig_raw,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [DELAY_TICKS:0]   dly_q;

    for (genvar gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
        if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= trig_raw;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[gi] <= 1'b0;
                else        sync_q[gi] <= sync_q[gi-1];
            end
        end
    end

    // tick-rate delay line; the oldest two taps form the edge detector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dly_q <= '0;
        else if (tick)
            dly_q <= {dly_q[DELAY_TICKS-1:0], sync_q[SYNC_STAGES-1]};
    end

    assign rise = tick &  dly_q[DELAY_TICKS-1] & ~dly_q[DELAY_TICKS];
    assign fall = tick & ~dly_q[DELAY_TICKS-1] &  dly_q[DELAY_TICKS];

endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
    import burst_seq_pkg::*;
#(
    parameter int KICK_TICKS  = 18,
    parameter int QDOWN_TICKS = 38
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run,
    input  logic   tick,
    input  logic   rise,
    input  logic   fall,
    output phase_e state
);
    localparam int CNT_MAX = (KICK_TICKS > QDOWN_TICKS) ? KICK_TICKS : QDOWN_TICKS;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] KICK_LAST  = CW'(KICK_TICKS - 1);
    localparam logic [CW-1:0] QDOWN_LAST = CW'(QDOWN_TICKS - 1);

    phase_e        nxt;
    logic [CW-1:0] cnt_q, cnt_nxt;

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt_q;
        unique case (state)
            PH_HOME: begin
                if (rise) begin
                    nxt     = PH_KICK;
                    cnt_nxt = '0;
                end
            end
            PH_KICK: begin
                if (fall) begin
                    nxt     = PH_QDOWN;
                    cnt_nxt = '0;
                end else if (cnt_q == KICK_LAST) begin
                    nxt     = PH_LEVEL;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt_q + 1'b1;
                end
            end
            PH_LEVEL: begin
                if (fall) begin
                    nxt     = PH_QDOWN;
                    cnt_nxt = '0;
                end
            end
            PH_QDOWN: begin
                if (cnt_q == QDOWN_LAST) begin
                    nxt     = PH_HOME;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt_q + 1'b1;
                end
            end
            default: begin
                nxt     = PH_HOME;
                cnt_nxt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_HOME;
            cnt_q <= '0;
        end else if (!run) begin
            state <= PH_HOME;
            cnt_q <= '0;
        end else if (tick) begin
            state <= nxt;
            cnt_q <= cnt_nxt;
        end
    end

    // R2: the state only moves on a tick or under power-down
    assert_move_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(state));
    // R10: power-down leaves the machine at home
    assert_pd_home_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> state == PH_HOME);
    // R3: kick is entered only from home
    assert_kick_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_KICK && $past(state) != PH_KICK) |-> $past(state) == PH_HOME);
    // R4: level is entered only from kick
    assert_level_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_LEVEL && $past(state) != PH_LEVEL) |-> $past(state) == PH_KICK);
    // R6 R7: quick-down is entered only from kick or level
    assert_qdown_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_QDOWN && $past(state) != PH_QDOWN)
            |-> ($past(state) == PH_KICK || $past(state) == PH_LEVEL));
    // R8: home is re-entered only from quick-down or under power-down
    assert_home_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_HOME && $past(state) != PH_HOME)
            |-> ($past(state) == PH_QDOWN || !$past(run)));

endmodule

// File: rtl/burst_ramp_sequencer.sv
module burst_ramp_sequencer
    import burst_seq_pkg::*;
#(
    parameter int TICK_DIV    = 6,
    parameter int SYNC_STAGES = 2,
    parameter int DELAY_TICKS = 2,
    parameter int KICK_TICKS  = 18,
    parameter int QDOWN_TICKS = 38
) (
    input  logic       clk_mc,
    input  logic       rst_n,
    input  logic       run,
    input  logic       trig_in,
    output logic       home_en,
    output logic       kick_en,
    output logic       level_en,
    output logic       qdown_en,
    output logic [1:0] phase
);
    logic   tick, rise, fall;
    phase_e state;

    cycle_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk_mc),
        .rst_n (rst_n),
        .tick  (tick)
    );

    trig_edge_sense #(.SYNC_STAGES(SYNC_STAGES), .DELAY_TICKS(DELAY_TICKS)) u_edge (
        .clk      (clk_mc),
        .rst_n    (rst_n),
        .tick     (tick),
        .trig_raw (trig_in),
        .rise     (rise),
        .fall     (fall)
    );

    phase_fsm #(.KICK_TICKS(KICK_TICKS), .QDOWN_TICKS(QDOWN_TICKS)) u_fsm (
        .clk   (clk_mc),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick),
        .rise  (rise),
        .fall  (fall),
        .state (state)
    );

    always_comb begin
        home_en  = 1'b0;
        kick_en  = 1'b0;
        level_en = 1'b0;
        qdown_en = 1'b0;
        unique case (state)
            PH_HOME:  home_en  = 1'b1;
            PH_KICK:  kick_en  = 1'b1;
            PH_LEVEL: level_en = 1'b1;
            PH_QDOWN: qdown_en = 1'b1;
            default:  home_en  = 1'b1;
        endcase
    end

    assign phase = state;

    // R10: power-down forces the home enable on the following edge
    assert_pd_home_out_R10: assert property (@(posedge clk_mc) disable iff (!rst_n)
        !run |=> home_en);

endmodule

// File: tb/burst_ramp_sequencer_tb.sv
module burst_ramp_sequencer_tb;

    localparam int INF   = 1000000000;
    localparam int KICKC = 18 * 6;
    localparam int QDC   = 38 * 6;
    localparam int ROWS  = 6;
    localparam int HIGH_LEN [ROWS] = '{300, 108, 102, 114, 40, 700};
    localparam int OFFS     [ROWS] = '{0, 1, 3, 5, 2, 4};

    logic clk = 1'b0, clk_on = 1'b1;
    logic rst_n = 1'b0, run = 1'b1, trig = 1'b0;
    logic home_en, kick_en, level_en, qdown_en;
    logic [1:0] phase;

    int n_chk = 0, n_bad = 0, edge_cnt = 0;
    bit chk_en = 0, done = 0;
    int kick_at = INF, lvl_at = INF, q_at = INF, home_at = INF, pd_at = INF;

    always begin
        #2;
        if (clk_on) clk = ~clk;
    end

    burst_ramp_sequencer u_dut (
        .clk_mc(clk), .rst_n(rst_n), .run(run), .trig_in(trig),
        .home_en(home_en), .kick_en(kick_en), .level_en(level_en),
        .qdown_en(qdown_en), .phase(phase)
    );

    always @(posedge clk or negedge rst_n)
        if (!rst_n) edge_cnt <= 0;
        else        edge_cnt <= edge_cnt + 1;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, act, exp, edge_cnt);
        end
    endtask

    // state seen after the change tick: first tick edge at or after k0+3, plus two ticks
    function automatic int arrive(int k0);
        return ((k0 + 3 + 5) / 6) * 6 + 12;
    endfunction

    function automatic int exp_phase(int e);
        if (e >= pd_at)   return 0;
        if (e < kick_at)  return 0;
        if (lvl_at < q_at) begin
            if (e < lvl_at) return 1;
            if (e < q_at)   return 2;
        end else if (e < q_at) return 1;
        if (e < home_at)  return 3;
        return 0;
    endfunction

    function automatic int pack_out();
        return {home_en, kick_en, level_en, qdown_en, phase};
    endfunction

    function automatic int pack_exp(int p);
        return {p == 0, p == 1, p == 2, p == 3, 2'(p)};
    endfunction

    always @(negedge clk)
        if (chk_en)
            check("timeline R2 R3 R4 R5 R6 R7 R8 R11", pack_out(), pack_exp(exp_phase(edge_cnt)));

    task automatic clear_model();
        kick_at = INF; lvl_at = INF; q_at = INF; home_at = INF; pd_at = INF;
    endtask

    task automatic raise();
        @(negedge clk);
        trig    = 1'b1;
        q_at    = INF;
        home_at = INF;
        kick_at = arrive(edge_cnt);
        lvl_at  = kick_at + KICKC;
    endtask

    task automatic lower();
        @(negedge clk);
        trig    = 1'b0;
        q_at    = arrive(edge_cnt);
        if (q_at <= lvl_at) lvl_at = INF;
        home_at = q_at + QDC;
    endtask

    task automatic wait_edge(int e);
        while (edge_cnt < e) @(negedge clk);
    endtask

    initial begin
        #600000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hold;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", pack_out(), pack_exp(0));
        rst_n = 1'b1;
        chk_en = 1;

        // stimulus table: pulse widths and phase offsets
        for (int r = 0; r < ROWS; r++) begin
            clear_model();
            repeat (OFFS[r]) @(negedge clk);
            raise();
            repeat (HIGH_LEN[r] - 1) @(negedge clk);
            lower();
            wait_edge(home_at + 20);
            check("R8 back home", home_en, 1);
        end

        // R7 boundary: fall arriving on the last kick tick skips level
        clear_model();
        raise();
        repeat (KICKC - 1) @(negedge clk);
        lower();
        wait_edge(q_at);
        check("R7 abort on kick end", qdown_en, 1);
        wait_edge(home_at + 10);

        // R9: rise during quick-down ignored, held trigger does not restart
        clear_model();
        raise();
        repeat (199) @(negedge clk);
        lower();
        wait_edge(q_at + 60);
        trig = 1'b1;
        wait_edge(home_at + 100);
        check("R9 held trigger no restart", home_en, 1);
        @(negedge clk); trig = 1'b0;
        repeat (40) @(negedge clk);
        check("R9 fall in home ignored", home_en, 1);

        // R10: power-down in level forces home, edges during power-down discarded
        clear_model();
        raise();
        wait_edge(lvl_at + 30);
        check("R10 level before power-down", level_en, 1);
        @(negedge clk);
        run = 1'b0;
        pd_at = edge_cnt + 1;
        @(negedge clk);
        check("R10 home after power-down", home_en, 1);
        repeat (10) @(negedge clk); trig = 1'b0;
        repeat (20) @(negedge clk); trig = 1'b1;
        repeat (40) @(negedge clk);
        run = 1'b1;
        clear_model();
        repeat (80) @(negedge clk);
        check("R10 discarded edge", home_en, 1);
        @(negedge clk); trig = 1'b0;
        repeat (40) @(negedge clk);

        // R12: clock pause in kick freezes outputs, timing resumes
        clear_model();
        raise();
        wait_edge(kick_at + 30);
        hold = pack_out();
        clk_on = 1'b0;
        #400;
        check("R12 frozen during pause", pack_out(), hold);
        clk_on = 1'b1;
        wait_edge(lvl_at);
        check("R12 level after resume", level_en, 1);
        repeat (19) @(negedge clk);
        lower();
        wait_edge(home_at + 10);
        check("R12 home after resume", home_en, 1);

        chk_en = 0;
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule